// File: doc/BRIEF.md
# Dual-Row 2x2 Max Pooling Unit

This unit reduces an unsigned 8-bit feature map by 2x2 max pooling with stride 2. The input map is held one image row per memory word, and the rows are numbered from 1. Both ports of a dual-port input memory are read in the same cycle. The odd port walks the row addresses 1, 3, 5, … and the even port walks 2, 4, 6, …, so every fetch returns one adjacent pair of rows.

Each fetch supplies two rows of `COLS` operands, 14 by default. A bank of comparators reduces them to one row of `COLS/2` maxima. The result row is written to a second memory at half the number of input rows consumed so far, so pair k (counting from 0) lands at output address k+1.

A controller issues the pair `k = 0 … ROWS/2-1` on consecutive cycles after a start pulse. It asserts a one-cycle done pulse once the final result row has been written.

Top module: `pool2x2_dual_row`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are all low.
- R2: A `start_i` sampled high while idle makes `busy_o` and `rd_en_o` high in the next cycle, with odd address 1 and even address 2.
- R3: The unit issues `ROWS/2` reads on consecutive cycles. For pair k, the odd port presents address 2k+1 and the even port presents address 2k+2.
- R4: Each read produces a write exactly one cycle later. The read memory has one cycle of latency. The write for pair k uses output address k+1.
- R5: Column c of a row occupies bits `[8c+7:8c]`. Output column j, at bits `[8j+7:8j]` of `wr_data_o`, is the maximum of columns 2j and 2j+1 of both rows in the pair.
- R6: All comparisons are unsigned, so a value of 8'h80 or above wins over any value below 8'h80.
- R7: `done_o` is high for exactly one cycle, the cycle after the last write. `busy_o` is low in that cycle.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. It causes no extra reads or writes and does not disturb the running sequence.
- R9: A `start_i` sampled in the cycle where `done_o` is high is accepted and begins a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pooling pass |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| rd_en_o | output | 1 | Read enable for both input ports |
| rd_addr_odd_o | output | ADDR_W | Odd-row address (1, 3, 5, …) |
| rd_addr_even_o | output | ADDR_W | Even-row address (2, 4, 6, …) |
| rd_data_odd_i | input | COLS*8 | Row returned on the odd port |
| rd_data_even_i | input | COLS*8 | Row returned on the even port |
| wr_en_o | output | 1 | Output memory write enable |
| wr_addr_o | output | ADDR_W | Output row address, k+1 for pair k |
| wr_data_o | output | COLS/2*8 | Pooled row |

## Verification
Two functions can fall in the same cycle: the done pulse that ends one pass and the acceptance of a start for the next. The bench waits until it sees `done_o` high and raises `start_i` in that very cycle. The scoreboard then requires that the first read of the new pass appears one cycle later, with addresses 1 and 2, and that no pulse or pass is lost. It also raises `start_i` in the middle of a pass, where the scoreboard flags any read or write that it did not queue.

// File: rtl/pool_pkg.sv
package pool_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DRAIN = 2'd2
  } pool_state_e;
endpackage

// File: rtl/pool_row_seq.sv
module pool_row_seq
  import pool_pkg::*;
#(
  parameter int ROWS   = 14,
  parameter int ADDR_W = 4,
  localparam int PAIRS = ROWS / 2,
  localparam int CNT_W = $clog2(PAIRS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              drain_o,
  output logic              rd_en_o,
  output logic [CNT_W-1:0]  pair_o,
  output logic [ADDR_W-1:0] addr_odd_o,
  output logic [ADDR_W-1:0] addr_even_o
);
  pool_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic last_pair;

  assign last_pair = (cnt_q == CNT_W'(PAIRS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_READ;
          cnt_q   <= '0;
        end
        ST_READ: begin
          if (last_pair) state_q <= ST_DRAIN;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign drain_o     = (state_q == ST_DRAIN);
  assign rd_en_o     = (state_q == ST_READ);
  assign pair_o      = cnt_q;
  assign addr_odd_o  = ADDR_W'({cnt_q, 1'b1});
  assign addr_even_o = ADDR_W'({cnt_q, 1'b1}) + ADDR_W'(1);

  AST_ODD_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !last_pair) |=> (rd_en_o && addr_odd_o == $past(addr_odd_o) + ADDR_W'(2))); // R3
  AST_PAIR_ADJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (addr_even_o == addr_odd_o + ADDR_W'(1))); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !last_pair && start_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
endmodule

// File: rtl/pool_max_row.sv
module pool_max_row #(
  parameter int COLS   = 14,
  parameter int DATA_W = 8,
  localparam int OCOLS = COLS / 2
) (
  input  logic [COLS*DATA_W-1:0]  row_a_i,
  input  logic [COLS*DATA_W-1:0]  row_b_i,
  output logic [OCOLS*DATA_W-1:0] max_o
);
  for (genvar j = 0; j < OCOLS; j++) begin : g_win
    logic [DATA_W-1:0] a0, a1, b0, b1, ma, mb;
    assign a0 = row_a_i[(2*j)*DATA_W +: DATA_W];
    assign a1 = row_a_i[(2*j+1)*DATA_W +: DATA_W];
    assign b0 = row_b_i[(2*j)*DATA_W +: DATA_W];
    assign b1 = row_b_i[(2*j+1)*DATA_W +: DATA_W];
    // unsigned compare: operands are plain logic vectors
    assign ma = (a0 >= a1) ? a0 : a1;
    assign mb = (b0 >= b1) ? b0 : b1;
    assign max_o[j*DATA_W +: DATA_W] = (ma >= mb) ? ma : mb;
  end
endmodule

// File: rtl/pool_wr_align.sv
module pool_wr_align #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              drain_i,
  input  logic [CNT_W-1:0]  pair_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o <= rd_en_i;
      done_o  <= drain_i;
      if (rd_en_i) wr_addr_o <= ADDR_W'(pair_i) + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/pool2x2_dual_row.sv
module pool2x2_dual_row #(
  parameter int ROWS   = 14,
  parameter int COLS   = 14,
  parameter int DATA_W = 8,
  localparam int OCOLS  = COLS / 2,
  localparam int ADDR_W = $clog2(ROWS + 1),
  localparam int CNT_W  = $clog2(ROWS / 2 + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    rd_en_o,
  output logic [ADDR_W-1:0]       rd_addr_odd_o,
  output logic [ADDR_W-1:0]       rd_addr_even_o,
  input  logic [COLS*DATA_W-1:0]  rd_data_odd_i,
  input  logic [COLS*DATA_W-1:0]  rd_data_even_i,
  output logic                    wr_en_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [OCOLS*DATA_W-1:0] wr_data_o
);
  logic drain;
  logic [CNT_W-1:0] pair;

  pool_row_seq #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .drain_o(drain), .rd_en_o(rd_en_o), .pair_o(pair),
    .addr_odd_o(rd_addr_odd_o), .addr_even_o(rd_addr_even_o)
  );

  pool_max_row #(.COLS(COLS), .DATA_W(DATA_W)) u_max (
    .row_a_i(rd_data_odd_i), .row_b_i(rd_data_even_i), .max_o(wr_data_o)
  );

  pool_wr_align #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_o), .drain_i(drain),
    .pair_i(pair), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .done_o(done_o)
  );

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> wr_en_o); // R4
  AST_WR_ADDR_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> (wr_addr_o == ADDR_W'($past(rd_addr_even_o) >> 1))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && !wr_en_o && !busy_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_NO_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_en_o); // R8
endmodule

// File: tb/pool2x2_dual_row_tb_top.sv
`timescale 1ns/1ps
module pool2x2_dual_row_tb_top;
  localparam int ROWS = 14, COLS = 14, DW = 8, OCOLS = COLS / 2;
  localparam int AW = $clog2(ROWS + 1);
  localparam int PAIRS = ROWS / 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, rd_en_o, wr_en_o;
  logic [AW-1:0] rd_addr_odd_o, rd_addr_even_o, wr_addr_o;
  logic [COLS*DW-1:0] rd_data_odd_i = '0, rd_data_even_i = '0;
  logic [OCOLS*DW-1:0] wr_data_o;

  always #2 clk_i = ~clk_i;

  pool2x2_dual_row #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW)) dut_i (.*);

  logic [COLS*DW-1:0] mem [0:(1<<AW)-1];
  always @(posedge clk_i) if (rd_en_o) begin
    rd_data_odd_i  <= mem[rd_addr_odd_o];
    rd_data_even_i <= mem[rd_addr_even_o];
  end

  int checks = 0, errors = 0;
  logic [2*AW-1:0] rd_q [$];
  logic [AW+OCOLS*DW-1:0] wr_q [$];
  logic exp_done = 1'b0;
  int runs_done = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OCOLS*DW-1:0] pool_ref(input logic [COLS*DW-1:0] a, input logic [COLS*DW-1:0] b);
    logic [OCOLS*DW-1:0] r;
    for (int j = 0; j < OCOLS; j++) begin
      int unsigned m = 0;
      for (int c = 2*j; c <= 2*j+1; c++) begin
        if (int'(a[c*DW +: DW]) > m) m = int'(a[c*DW +: DW]);
        if (int'(b[c*DW +: DW]) > m) m = int'(b[c*DW +: DW]);
      end
      r[j*DW +: DW] = DW'(m);
    end
    return r;
  endfunction

  // driver: queue expected reads/writes, pulse start (R2, R3, R4, R5)
  task automatic launch();
    for (int k = 0; k < PAIRS; k++) begin
      rd_q.push_back({AW'(2*k+1), AW'(2*k+2)});
      wr_q.push_back({AW'(k+1), pool_ref(mem[2*k+1], mem[2*k+2])});
    end
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", 128'(busy_o), 128'd1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((wr_q.size() != 0 || busy_o || exp_done) && n < 100) begin
      @(negedge clk_i);
      n++;
    end
    chk(!busy_o && rd_q.size() == 0 && wr_q.size() == 0, "R8 pass drained", 128'(rd_q.size()), 128'd0);
  endtask

  // monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (exp_done) begin
      chk(done_o === 1'b1 && busy_o === 1'b0, "R7 done pulse", {done_o, busy_o}, 2'b10);
      exp_done = 1'b0;
      runs_done++;
    end else if (done_o) begin
      chk(1'b0, "R7 spurious done", 128'(done_o), 128'd0);
    end
    if (rd_en_o) begin
      if (rd_q.size() == 0) chk(1'b0, "R8 unexpected read", 128'(rd_addr_odd_o), 128'd0);
      else begin
        logic [2*AW-1:0] e;
        e = rd_q.pop_front();
        chk({rd_addr_odd_o, rd_addr_even_o} === e, "R3 read addresses",
            128'({rd_addr_odd_o, rd_addr_even_o}), 128'(e));
      end
    end
    if (wr_en_o) begin
      if (wr_q.size() == 0) chk(1'b0, "R4 unexpected write", 128'(wr_addr_o), 128'd0);
      else begin
        logic [AW+OCOLS*DW-1:0] e;
        e = wr_q.pop_front();
        chk(wr_addr_o === e[AW+OCOLS*DW-1 -: AW], "R4 write address",
            128'(wr_addr_o), 128'(e[AW+OCOLS*DW-1 -: AW]));
        chk(wr_data_o === e[OCOLS*DW-1:0], "R5 R6 pooled row", 128'(wr_data_o), 128'(e[OCOLS*DW-1:0]));
        if (wr_q.size() == 0) exp_done = 1'b1;
      end
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, rd_en_o, wr_en_o} === 4'b0, "R1 reset outputs",
        128'({busy_o, done_o, rd_en_o, wr_en_o}), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, rd_en_o} === 2'b0, "R1 idle after reset", 128'({busy_o, rd_en_o}), 128'd0);

    // random map
    for (int r = 1; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) mem[r][c*DW +: DW] = DW'($urandom);
    launch();
    wait_idle();

    // R6: values around the sign boundary
    for (int r = 1; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int s = (r + c) % 4;
        mem[r][c*DW +: DW] = (s == 0) ? 8'hFF : (s == 1) ? 8'h7F : (s == 2) ? 8'h80 : 8'h01;
      end
    mem[1][0 +: DW] = 8'h7F; mem[2][0 +: DW] = 8'h00;
    mem[1][DW +: DW] = 8'h00; mem[2][DW +: DW] = 8'h80;
    launch();
    wait_idle();

    // R8: start raised mid-pass
    for (int r = 1; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) mem[r][c*DW +: DW] = DW'(r * 16 + c);
    launch();
    @(negedge clk_i);
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();

    // R9: start in the done cycle
    for (int r = 1; r <= ROWS; r++)
      for (int c = 0; c < COLS; c++) mem[r][c*DW +: DW] = DW'($urandom);
    launch();
    while (!done_o) @(negedge clk_i);
    launch();
    wait_idle();
    chk(runs_done == 5, "R9 pass count", 128'(runs_done), 128'd5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog R7 act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule